// File: doc/BRIEF.md
# CRC-24 Append and Check Unit

A streaming unit for a bit-serial block path. In transmit mode it forwards a payload unchanged and then emits a 24-bit cyclic redundancy remainder computed over that payload. In check mode it accepts payload followed by its 24 parity bits. It recomputes the remainder over everything it received and forwards only the payload. With the last payload bit it reports whether the block is intact, so that a later stage can decide on a retransmission.

Two generator polynomials are available and are chosen per block: a transport-block polynomial and a code-block polynomial. Both sides use a valid/ready handshake with start-of-block and end-of-block markers. Backpressure from the output side stalls the input side.

Top module: `crc24_unit`

## Requirements
- R1: After reset, with no input offered, `out_valid` and `chk_done` are low.
- R2: In transmit mode (`mode`=0), every payload bit leaves on `out_bit` unchanged and in order. `out_sop` is high on the first payload bit.
- R3: In transmit mode, the payload is followed by exactly 24 parity bits, most significant first, with `out_eop` on the last parity bit. With `poly_sel`=0 they are the remainder of the zero-initialised division by polynomial 0x864CFB (x^24 implied). While they are being sent, `in_ready` is low.
- R4: With `poly_sel`=1 the polynomial is 0x800063. `mode` and `poly_sel` are taken only from the bit that carries `in_sop`. Their values on later bits of the block have no effect.
- R5: In check mode (`mode`=1), the output is the input stream with its final 24 bits removed. `out_sop` marks the first payload bit and `out_eop` marks the last payload bit. A check-mode block must hold at least 25 bits.
- R6: In check mode, `chk_done` is high together with the last payload output bit. `chk_fail` is low there when the received parity equals the remainder of the payload.
- R7: A check-mode block with any one bit inverted, in the payload or in the parity, gives `chk_fail` high with `chk_done`.
- R8: With `out_ready` held low for any number of cycles, no bit is lost or repeated. A pending output bit stays stable.
- R9: The remainder register restarts from zero at every block, so back-to-back blocks of either mode and polynomial are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 1 | 0 transmit/append, 1 check/strip; sampled with `in_sop` |
| poly_sel | input | 1 | 0 transport-block polynomial, 1 code-block polynomial; sampled with `in_sop` |
| in_valid | input | 1 | Input bit present |
| in_ready | output | 1 | Input bit accepted this cycle if valid |
| in_bit | input | 1 | Input data bit |
| in_sop | input | 1 | First bit of a block |
| in_eop | input | 1 | Last bit of a block |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Downstream accepts output bit |
| out_bit | output | 1 | Output data bit |
| out_sop | output | 1 | First output bit of a block |
| out_eop | output | 1 | Last output bit of a block |
| chk_done | output | 1 | Check result present (check mode, last payload bit) |
| chk_fail | output | 1 | Received parity does not match |

## Verification
A wrong remainder register shows up at the ports only at the end of a block. In transmit mode it shows in the appended parity bits. In check mode it shows as a wrong `chk_fail`, so each block needs an end-to-end comparison rather than a comparison per bit. A fault in the 24-bit delay line or its fill count shows up much sooner: a shifted, dropped or repeated payload bit, or a misplaced `out_sop`/`out_eop`, appears within the first output bits of a check-mode block. Random output stalls and back-to-back blocks of both polynomials expose state left over from one block to the next.

// File: rtl/crc24_unit.sv
module crc24_unit #(
  parameter int W = 24,
  parameter logic [W-1:0] POLY_A = 24'h864CFB,
  parameter logic [W-1:0] POLY_B = 24'h800063
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic poly_sel,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic in_sop,
  input  logic in_eop,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic out_sop,
  output logic out_eop,
  output logic chk_done,
  output logic chk_fail
);
  localparam int CW = $clog2(W + 1);

  logic          in_blk, app, chk_r, sel_r, first_pend;
  logic [W-1:0]  crc, dly;
  logic [CW-1:0] cnt, fill;

  wire           chk       = in_blk ? chk_r : mode;
  wire           sel       = in_blk ? sel_r : poly_sel;
  wire [W-1:0]   crc_base  = in_blk ? crc : '0;
  wire [CW-1:0]  fill_base = in_blk ? fill : '0;
  wire           full      = (fill_base == CW'(W));
  wire [W-1:0]   poly      = sel ? POLY_B : POLY_A;
  wire           fb        = crc_base[W-1] ^ in_bit;
  wire [W-1:0]   crc_step  = {crc_base[W-2:0], 1'b0} ^ (fb ? poly : '0);
  wire           take      = in_valid && in_ready;

  always_comb begin
    if (app) begin
      out_valid = 1'b1;
      out_bit   = crc[W-1];
      out_sop   = 1'b0;
      out_eop   = (cnt == CW'(1));
      in_ready  = 1'b0;
    end else if (chk) begin
      out_valid = in_valid && full;
      out_bit   = dly[W-1];
      out_sop   = first_pend;
      out_eop   = in_eop;
      in_ready  = full ? out_ready : 1'b1;
    end else begin
      out_valid = in_valid;
      out_bit   = in_bit;
      out_sop   = in_sop;
      out_eop   = 1'b0;
      in_ready  = out_ready;
    end
  end

  assign chk_done = !app && chk && in_valid && full && in_eop;
  assign chk_fail = chk_done && (crc_step != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_blk     <= 1'b0;
      app        <= 1'b0;
      chk_r      <= 1'b0;
      sel_r      <= 1'b0;
      first_pend <= 1'b0;
      crc        <= '0;
      dly        <= '0;
      cnt        <= '0;
      fill       <= '0;
    end else if (app) begin
      if (out_ready) begin
        crc <= {crc[W-2:0], 1'b0};
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) app <= 1'b0;
      end
    end else if (take) begin
      crc    <= crc_step;
      in_blk <= !in_eop;
      chk_r  <= chk;
      sel_r  <= sel;
      if (chk) begin
        dly        <= {dly[W-2:0], in_bit};
        fill       <= full ? fill_base : fill_base + CW'(1);
        first_pend <= full ? 1'b0 : (in_blk ? first_pend : 1'b1);
      end else if (in_eop) begin
        app <= 1'b1;
        cnt <= CW'(W);
      end
    end
  end

  assert_append_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    app && !out_ready |=> app && $stable(out_bit) && $stable(out_eop));

  assert_append_blocks_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    app |-> !in_ready);

  assert_done_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> out_valid && out_eop);

  assert_fail_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail |-> chk_done);

  assert_parity_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    app && out_ready && out_eop |=> !app);

  assert_check_holds_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_blk && chk_r && out_valid && !out_ready |=> $stable(out_bit));

endmodule

// File: tb/crc24_unit_test.sv
module crc24_unit_test;
  logic clk = 0, rst_n = 0;
  logic mode = 0, poly_sel = 0, in_valid = 0, in_bit = 0, in_sop = 0, in_eop = 0, out_ready = 0;
  logic in_ready, out_valid, out_bit, out_sop, out_eop, chk_done, chk_fail;

  always #10 clk = ~clk;

  crc24_unit uut (.clk(clk), .rst_n(rst_n), .mode(mode), .poly_sel(poly_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit), .in_sop(in_sop),
    .in_eop(in_eop), .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .out_sop(out_sop), .out_eop(out_eop), .chk_done(chk_done), .chk_fail(chk_fail));

  typedef struct { bit b; bit sop; bit eop; bit done; bit fail; string tag; } item_t;
  item_t exp_q[$];
  int checks = 0, fails = 0, cycles = 0;
  bit stall_on = 0;

  function automatic logic [23:0] crc_ref(bit q[$], bit sel);
    logic [23:0] r = '0;
    logic [23:0] p = sel ? 24'h800063 : 24'h864CFB;
    foreach (q[i]) begin
      logic f = r[23] ^ q[i];
      r = {r[22:0], 1'b0} ^ (f ? p : 24'h0);
    end
    return r;
  endfunction

  task automatic put_bit(bit b, bit sop, bit eop, bit chk, bit sel);
    in_valid = 1; in_bit = b; in_sop = sop; in_eop = eop;
    mode     = sop ? chk : 1'($urandom);   // R4: non-sop values must not matter
    poly_sel = sop ? sel : 1'($urandom);
    forever begin
      @(negedge clk);
      if (in_ready) begin @(posedge clk); #1; break; end
      @(posedge clk); #1;
    end
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic run_block(bit chk, bit sel, int n, int flip, string first_tag, string last_tag);
    bit pay[$];
    bit stream[$];
    logic [23:0] par;
    for (int i = 0; i < n; i++) pay.push_back(1'($urandom));
    par = crc_ref(pay, sel);
    if (!chk) begin
      for (int i = 0; i < n; i++)
        exp_q.push_back('{pay[i], i == 0, 0, 0, 0, i == 0 ? first_tag : "R2"});
      for (int i = 0; i < 24; i++)
        exp_q.push_back('{par[23-i], 0, i == 23, 0, 0, i == 23 ? last_tag : (sel ? "R4" : "R3")});
      stream = pay;
      for (int i = 0; i < 24; i++) stream.push_back(par[23-i]);
    end else begin
      stream = pay;
      for (int i = 0; i < 24; i++) stream.push_back(par[23-i]);
      if (flip >= 0) stream[flip] = !stream[flip];
      for (int i = 0; i < n; i++)
        exp_q.push_back('{stream[i], i == 0, i == n-1, i == n-1, (i == n-1) && (flip >= 0),
                          i == n-1 ? last_tag : (i == 0 ? first_tag : "R5")});
      stream = stream;
    end
    if (chk) begin
      for (int i = 0; i < stream.size(); i++) put_bit(stream[i], i == 0, i == stream.size()-1, chk, sel);
    end else begin
      for (int i = 0; i < n; i++) put_bit(stream[i], i == 0, i == n-1, chk, sel);
    end
  endtask

  // R8: random output stalls
  always @(posedge clk) begin
    #1 out_ready = stall_on ? ($urandom_range(0, 9) < 6) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      item_t e;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5 unexpected output bit=%0d expected none", out_bit);
      end else begin
        e = exp_q.pop_front();
        if ({out_bit, out_sop, out_eop, chk_done, chk_fail} != {e.b, e.sop, e.eop, e.done, e.fail}) begin
          fails++;
          $display("FAIL %s bit/sop/eop/done/fail actual %b%b%b%b%b expected %b%b%b%b%b",
                   e.tag, out_bit, out_sop, out_eop, chk_done, chk_fail,
                   e.b, e.sop, e.eop, e.done, e.fail);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 0 || chk_done !== 0) begin
      fails++;
      $display("FAIL R1 out_valid/chk_done actual %b%b expected 00", out_valid, chk_done);
    end
    rst_n = 1;
    @(posedge clk); #1;

    run_block(0, 0, 8,  -1, "R2", "R3");
    run_block(0, 1, 40, -1, "R2", "R4");
    run_block(0, 0, 1,  -1, "R2", "R3");
    run_block(1, 0, 30, -1, "R5", "R6");
    run_block(1, 1, 1,  -1, "R5", "R6");
    run_block(1, 0, 20, 5,  "R5", "R7");
    run_block(1, 1, 16, 30, "R5", "R7");
    stall_on = 1;
    run_block(0, 1, 33, -1, "R8", "R8");
    run_block(1, 0, 27, -1, "R8", "R8");
    // R9: back-to-back random blocks, mixed mode and polynomial
    for (int k = 0; k < 24; k++) begin
      bit c = 1'($urandom);
      int n = $urandom_range(1, 60);
      int f = (c && $urandom_range(0, 2) == 0) ? $urandom_range(0, n + 23) : -1;
      run_block(c, 1'($urandom), n, f, "R9", f >= 0 ? "R7" : "R9");
    end
    repeat (60) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R8 outstanding items actual %0d expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule